// File: doc/BRIEF.md
# Privilege-Gated Bus Address Decoder

This block sits between a 32-bit processor bus and the memories and peripheral cores of a small security device. It splits each bus address into a top-level region (boot ROM, main RAM, a reserved hole and the peripheral window), then picks one peripheral core from a six-bit core code. It drives one select strobe per target and returns the selected read data to the processor. Every access completes in the cycle it is presented.

The block also owns the device's privilege state. After reset the device runs in loader mode, which has full access. When the loader writes a non-zero word to the mode-switch register, the block enters application mode, and only a reset brings it back. In application mode the secret-store core and the loader-private RAM disappear from the map. The application address, application size and compound-identifier words become read-only.

A small system register file is built in. It holds two fixed name words, a version word, the application address and size, eight compound-identifier words and a byte-wide debug output port.

Top module: `mmio_gate`

## Requirements
- R1: Address bits [31:30] pick the region: 00 drives `romSel` and returns `romRdata`, 01 drives `ramSel` and returns `ramRdata`, 10 is reserved and 11 is the peripheral window.
- R2: In the peripheral window, bits [29:24] pick a core. The codes are 0x00 entropy (coreSel bit 0), 0x01 timer (bit 1), 0x02 secret store (bit 2), 0x03 serial port (bit 3), 0x04 touch sensor (bit 4), 0x10 loader RAM (bit 5) and 0x3F system registers (no select line). A selected core's word from `coreRdata[32*i +: 32]` is returned.
- R3: A reserved-region access, or an access to a core code not listed in R2, raises no select and reads as zero.
- R4: A full-word write of a non-zero value to system word 4 (byte offset 0x10) sets `appMode` on the next clock edge. Writing zero does nothing. Once set, `appMode` stays set until reset, and further writes to word 4 are ignored.
- R5: While `appMode` is set, accesses to the secret store and the loader RAM raise no select and read as zero.
- R6: The application address (word 8), application size (word 9) and compound-identifier words (words 16 to 23) reset to zero. Full-word writes update them in loader mode. Writes leave them unchanged in application mode.
- R7: System words 0, 1 and 2 read as 0x6D746131 ("mta1"), 0x6D6B6466 ("mkdf") and 1 in both modes. Words 4 and 5 read as zero.
- R8: The system registers and the cores of bits 0 to 4 accept only full-word writes (strobe 4'hF). A partial write raises no select and changes no register. The loader RAM takes any strobe. The debug port (word 5) accepts a write whose strobe bit 0 is set: it pulses `dbgValid` and presents `busWdata[7:0]` on `dbgByte`.
- R9: A cycle with `softRst` high clears `appMode`, the application address and size, and the compound-identifier words.
- R10: `busReady` equals `busValid` in every cycle, blocked and ignored writes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous software reset of the mode and writable registers |
| busValid | input | 1 | Access request |
| busWe | input | 1 | Write when high, read when low |
| busAddr | input | 32 | Byte address |
| busWdata | input | 32 | Write data |
| busStrb | input | 4 | Byte-lane write strobes |
| busReady | output | 1 | Access completes this cycle |
| busRdata | output | 32 | Read data to the processor |
| romSel | output | 1 | Boot ROM select |
| ramSel | output | 1 | Main RAM select |
| coreSel | output | 6 | One-hot peripheral core selects |
| romRdata | input | 32 | Read data from the ROM |
| ramRdata | input | 32 | Read data from the RAM |
| coreRdata | input | 192 | Read data of the six cores, 32 bits each |
| dbgValid | output | 1 | Debug byte write strobe |
| dbgByte | output | 8 | Debug byte |
| appMode | output | 1 | High in application mode |

## Verification
A mode flag that is wrong after a switch or a software reset shows on the very next access. The secret store and the loader RAM then appear or vanish on `coreSel` and `busRdata`, and the protected registers accept or refuse writes. A decode slip shows in the same cycle as a wrong one-hot select or a wrong word, so the bench sweeps all 64 core codes in both modes. A dropped or spurious register write shows on the next read of that register, so every writable word is written and read back under both privileges and under partial strobes.

// File: rtl/mmio_gate_pkg.sv
package mmio_gate_pkg;
  localparam int NCORE     = 6;
  localparam int CDI_WORDS = 8;
  localparam int CDI_IW    = $clog2(CDI_WORDS);

  localparam logic [5:0] SYS_CODE = 6'h3f;
  // cores hidden in application mode, and cores taking byte writes
  localparam logic [NCORE-1:0] HIDE_MASK = 6'b100100;
  localparam logic [NCORE-1:0] BYTE_MASK = 6'b100000;

  localparam logic [5:0] W_NAME0  = 6'd0;
  localparam logic [5:0] W_NAME1  = 6'd1;
  localparam logic [5:0] W_VER    = 6'd2;
  localparam logic [5:0] W_SWITCH = 6'd4;
  localparam logic [5:0] W_DBG    = 6'd5;
  localparam logic [5:0] W_ADDR   = 6'd8;
  localparam logic [5:0] W_SIZE   = 6'd9;
  localparam logic [5:0] W_CDI0   = 6'd16;

  function automatic logic [5:0] coreCode(input int idx);
    case (idx)
      0: coreCode = 6'h00;
      1: coreCode = 6'h01;
      2: coreCode = 6'h02;
      3: coreCode = 6'h03;
      4: coreCode = 6'h04;
      default: coreCode = 6'h10;
    endcase
  endfunction

  typedef struct packed {
    logic             romHit;
    logic             ramHit;
    logic [NCORE-1:0] coreHit;
    logic             sysHit;
    logic             sysWrFull;
    logic [5:0]       sysWord;
    logic             appMode;
    logic             clr;
  } gateStrb_t;
endpackage

// File: rtl/mmio_gate_ctrl.sv
module mmio_gate_ctrl
  import mmio_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic        busValid,
  input  logic        busWe,
  input  logic [31:0] busAddr,
  input  logic [31:0] busWdata,
  input  logic [3:0]  busStrb,
  output gateStrb_t   strb,
  output logic        dbgValid,
  output logic [7:0]  dbgByte
);
  logic [1:0]       region;
  logic [5:0]       code;
  logic             fullWord;
  logic             mmioHit;
  logic             sysHit;
  logic [5:0]       sysWord;
  logic             switchReq;
  logic             appModeQ;
  logic [NCORE-1:0] coreHit;

  assign region   = busAddr[31:30];
  assign code     = busAddr[29:24];
  assign fullWord = (busStrb == 4'hf);
  assign mmioHit  = busValid && (region == 2'b11);
  assign sysWord  = busAddr[7:2];
  assign sysHit   = mmioHit && (code == SYS_CODE) &&
                    (busAddr[23:8] == 16'h0) && (busAddr[1:0] == 2'b00);

  genvar gi;
  generate
    for (gi = 0; gi < NCORE; gi++) begin : g_core
      assign coreHit[gi] = mmioHit && (code == coreCode(gi)) &&
                           !(HIDE_MASK[gi] && appModeQ) &&
                           (!busWe || fullWord || BYTE_MASK[gi]);
    end
  endgenerate

  assign switchReq = sysHit && busWe && fullWord &&
                     (sysWord == W_SWITCH) && (busWdata != 32'h0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          appModeQ <= 1'b0;
    else if (softRst)   appModeQ <= 1'b0;
    else if (switchReq) appModeQ <= 1'b1;
  end

  assign dbgValid = sysHit && busWe && busStrb[0] && (sysWord == W_DBG);
  assign dbgByte  = busWdata[7:0];

  always_comb begin
    strb           = '0;
    strb.romHit    = busValid && (region == 2'b00);
    strb.ramHit    = busValid && (region == 2'b01);
    strb.coreHit   = coreHit;
    strb.sysHit    = sysHit;
    strb.sysWrFull = sysHit && busWe && fullWord;
    strb.sysWord   = sysWord;
    strb.appMode   = appModeQ;
    strb.clr       = softRst;
  end

  // R1/R2: at most one target selected
  p_onehot_sel_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.romHit, strb.ramHit, coreHit, sysHit}));

  // R4: application mode is sticky until a reset
  p_sticky_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    (appModeQ && !softRst) |=> appModeQ);

  // R4: a qualifying switch write enters application mode
  p_switch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWe && busAddr == 32'hff00_0010 && busStrb == 4'hf &&
     busWdata != 32'h0 && !softRst) |=> appModeQ);

  // R5: hidden cores never selected in application mode
  p_hidden_r5: assert property (@(posedge clk) disable iff (!rstN)
    appModeQ |-> (!coreHit[2] && !coreHit[5]));

  // R9: software reset returns to loader mode
  p_softrst_r9: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !appModeQ);
endmodule

// File: rtl/mmio_gate_dp.sv
module mmio_gate_dp
  import mmio_gate_pkg::*;
#(
  parameter logic [31:0] NAME0_WORD = 32'h6d746131,
  parameter logic [31:0] NAME1_WORD = 32'h6d6b6466,
  parameter logic [31:0] VER_WORD   = 32'h0000_0001
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gateStrb_t             strb,
  input  logic [31:0]           busWdata,
  input  logic [31:0]           romRdata,
  input  logic [31:0]           ramRdata,
  input  logic [NCORE*32-1:0]   coreRdata,
  output logic [31:0]           busRdata
);
  logic [31:0] appAddrQ;
  logic [31:0] appSizeQ;
  logic [31:0] cdiQ [CDI_WORDS];
  logic        wrEn;
  logic [5:0]  cdiOff;
  logic        cdiHit;
  logic [31:0] sysRd;

  assign wrEn   = strb.sysWrFull && !strb.appMode;
  assign cdiOff = strb.sysWord - W_CDI0;
  assign cdiHit = (strb.sysWord >= W_CDI0) && (cdiOff < 6'(CDI_WORDS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      appAddrQ <= '0;
      appSizeQ <= '0;
    end else if (strb.clr) begin
      appAddrQ <= '0;
      appSizeQ <= '0;
    end else if (wrEn) begin
      if (strb.sysWord == W_ADDR) appAddrQ <= busWdata;
      if (strb.sysWord == W_SIZE) appSizeQ <= busWdata;
    end
  end

  genvar gk;
  generate
    for (gk = 0; gk < CDI_WORDS; gk++) begin : g_cdi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         cdiQ[gk] <= '0;
        else if (strb.clr) cdiQ[gk] <= '0;
        else if (wrEn && cdiHit && (cdiOff[CDI_IW-1:0] == CDI_IW'(gk)))
          cdiQ[gk] <= busWdata;
      end
    end
  endgenerate

  always_comb begin
    sysRd = '0;
    case (strb.sysWord)
      W_NAME0: sysRd = NAME0_WORD;
      W_NAME1: sysRd = NAME1_WORD;
      W_VER:   sysRd = VER_WORD;
      W_ADDR:  sysRd = appAddrQ;
      W_SIZE:  sysRd = appSizeQ;
      default: if (cdiHit) sysRd = cdiQ[cdiOff[CDI_IW-1:0]];
    endcase
  end

  always_comb begin
    busRdata = '0;
    if (strb.romHit) busRdata = romRdata;
    if (strb.ramHit) busRdata = ramRdata;
    if (strb.sysHit) busRdata = sysRd;
    for (int i = 0; i < NCORE; i++)
      if (strb.coreHit[i]) busRdata = coreRdata[i*32 +: 32];
  end

  // R6: protected registers frozen in application mode
  p_ro_app_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.appMode && !strb.clr) |=> ($stable(appAddrQ) && $stable(appSizeQ) && $stable(cdiQ[0])));

  // R9: software reset clears the writable registers
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (appAddrQ == 32'h0 && appSizeQ == 32'h0 && cdiQ[CDI_WORDS-1] == 32'h0));
endmodule

// File: rtl/mmio_gate.sv
module mmio_gate
  import mmio_gate_pkg::*;
#(
  parameter logic [31:0] NAME0_WORD = 32'h6d746131,
  parameter logic [31:0] NAME1_WORD = 32'h6d6b6466,
  parameter logic [31:0] VER_WORD   = 32'h0000_0001
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softRst,
  input  logic                busValid,
  input  logic                busWe,
  input  logic [31:0]         busAddr,
  input  logic [31:0]         busWdata,
  input  logic [3:0]          busStrb,
  output logic                busReady,
  output logic [31:0]         busRdata,
  output logic                romSel,
  output logic                ramSel,
  output logic [NCORE-1:0]    coreSel,
  input  logic [31:0]         romRdata,
  input  logic [31:0]         ramRdata,
  input  logic [NCORE*32-1:0] coreRdata,
  output logic                dbgValid,
  output logic [7:0]          dbgByte,
  output logic                appMode
);
  gateStrb_t strb;

  mmio_gate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .softRst  (softRst),
    .busValid (busValid),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busStrb  (busStrb),
    .strb     (strb),
    .dbgValid (dbgValid),
    .dbgByte  (dbgByte)
  );

  mmio_gate_dp #(
    .NAME0_WORD (NAME0_WORD),
    .NAME1_WORD (NAME1_WORD),
    .VER_WORD   (VER_WORD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .romRdata  (romRdata),
    .ramRdata  (ramRdata),
    .coreRdata (coreRdata),
    .busRdata  (busRdata)
  );

  assign busReady = busValid;
  assign romSel   = strb.romHit;
  assign ramSel   = strb.ramHit;
  assign coreSel  = strb.coreHit;
  assign appMode  = strb.appMode;

  // R3: reserved region reads zero and selects nothing
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr[31:30] == 2'b10) |->
      (busRdata == 32'h0 && !romSel && !ramSel && coreSel == '0));
endmodule

// File: tb/mmio_gate_bench.sv
module mmio_gate_bench;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         softRst = 1'b0;
  logic         busValid = 1'b0;
  logic         busWe = 1'b0;
  logic [31:0]  busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [3:0]   busStrb = '0;
  logic         busReady;
  logic [31:0]  busRdata;
  logic         romSel, ramSel;
  logic [5:0]   coreSel;
  logic [31:0]  romRdata, ramRdata;
  logic [191:0] coreRdata;
  logic         dbgValid;
  logic [7:0]   dbgByte;
  logic         appMode;

  int nChecks = 0;
  int nErr    = 0;
  bit done    = 0;

  logic [31:0] gotRd;
  logic [5:0]  gotSel;
  logic        gotRom, gotRam, gotRdy, gotDbg;
  logic [7:0]  gotDbgB;

  always #(CLK_NS/2) clk = ~clk;

  assign romRdata = busAddr ^ 32'ha5a5_0000;
  assign ramRdata = ~busAddr;
  always_comb
    for (int i = 0; i < 6; i++) coreRdata[i*32 +: 32] = 32'hcafe_0000 + 32'(i);

  mmio_gate u_mmio_gate (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .busValid(busValid), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busStrb(busStrb), .busReady(busReady),
    .busRdata(busRdata), .romSel(romSel), .ramSel(ramSel),
    .coreSel(coreSel), .romRdata(romRdata), .ramRdata(ramRdata),
    .coreRdata(coreRdata), .dbgValid(dbgValid), .dbgByte(dbgByte),
    .appMode(appMode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doAcc(input logic we, input logic [31:0] a, input logic [31:0] w,
                       input logic [3:0] s);
    @(negedge clk);
    busValid = 1'b1; busWe = we; busAddr = a; busWdata = w; busStrb = s;
    #1;
    gotRd = busRdata; gotSel = coreSel; gotRom = romSel; gotRam = ramSel;
    gotRdy = busReady; gotDbg = dbgValid; gotDbgB = dbgByte;
    @(posedge clk);
    #1;
    busValid = 1'b0; busWe = 1'b0; busStrb = 4'h0;
  endtask

  function automatic logic [31:0] sysA(input int w);
    return {8'hff, 16'h0, 6'(w), 2'b00};
  endfunction

  function automatic int expIdx(input logic [5:0] c);
    case (c)
      6'h00: return 0;
      6'h01: return 1;
      6'h02: return 2;
      6'h03: return 3;
      6'h04: return 4;
      6'h10: return 5;
      default: return -1;
    endcase
  endfunction

  task automatic sweep(input logic inApp);
    for (int c = 0; c < 64; c++) begin
      logic [31:0] eRd;
      logic [5:0]  eSel;
      int          idx;
      idx  = expIdx(6'(c));
      eRd  = '0;
      eSel = '0;
      if (c == 63) eRd = 32'h6d746131;
      else if (idx >= 0 && !(inApp && (idx == 2 || idx == 5))) begin
        eSel[idx] = 1'b1;
        eRd = 32'hcafe_0000 + 32'(idx);
      end
      doAcc(1'b0, {2'b11, 6'(c), 24'h0}, 32'h0, 4'h0);
      // R2 decode, R3 unassigned codes, R5 hidden cores in application mode
      chk(inApp ? "R5 core sel" : "R2 core sel", {26'h0, gotSel}, {26'h0, eSel});
      chk(inApp ? "R5 core rd"  : "R3 core rd",  gotRd, eRd);
    end
  endtask

  task automatic checkIds;
    doAcc(1'b0, sysA(0), 0, 0); chk("R7 name0", gotRd, 32'h6d746131);
    doAcc(1'b0, sysA(1), 0, 0); chk("R7 name1", gotRd, 32'h6d6b6466);
    doAcc(1'b0, sysA(2), 0, 0); chk("R7 version", gotRd, 32'h1);
    doAcc(1'b0, sysA(4), 0, 0); chk("R7 switch reads zero", gotRd, 32'h0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    chk("R4 reset mode", {31'h0, appMode}, 32'h0);
    doAcc(1'b0, sysA(8), 0, 0); chk("R6 reset addr", gotRd, 32'h0);
    doAcc(1'b0, sysA(16), 0, 0); chk("R6 reset cdi", gotRd, 32'h0);

    // R1 region decode
    doAcc(1'b0, 32'h0000_1234, 0, 0);
    chk("R1 rom sel", {30'h0, gotRom, gotRam}, 32'h2);
    chk("R1 rom rd", gotRd, 32'h0000_1234 ^ 32'ha5a5_0000);
    doAcc(1'b0, 32'h4001_0040, 0, 0);
    chk("R1 ram sel", {30'h0, gotRom, gotRam}, 32'h1);
    chk("R1 ram rd", gotRd, ~32'h4001_0040);
    // R3 reserved region, R10 ready
    doAcc(1'b0, 32'h8000_0004, 0, 0);
    chk("R3 reserved rd", gotRd, 32'h0);
    chk("R3 reserved sel", {24'h0, gotRom, gotRam, gotSel}, 32'h0);
    chk("R10 ready", {31'h0, gotRdy}, 32'h1);

    sweep(1'b0);
    checkIds();

    // R6 writes in loader mode
    doAcc(1'b1, sysA(8), 32'h4001_0000, 4'hf);
    doAcc(1'b1, sysA(9), 32'h0000_1f00, 4'hf);
    for (int k = 0; k < 8; k++) doAcc(1'b1, sysA(16 + k), 32'h0101_0101 * (k + 1), 4'hf);
    doAcc(1'b0, sysA(8), 0, 0); chk("R6 addr wr", gotRd, 32'h4001_0000);
    doAcc(1'b0, sysA(9), 0, 0); chk("R6 size wr", gotRd, 32'h0000_1f00);
    for (int k = 0; k < 8; k++) begin
      doAcc(1'b0, sysA(16 + k), 0, 0);
      chk("R6 cdi wr", gotRd, 32'h0101_0101 * (k + 1));
    end

    // R8 strobe rules
    doAcc(1'b1, sysA(8), 32'h0, 4'h3);
    doAcc(1'b0, sysA(8), 0, 0); chk("R8 partial sys write", gotRd, 32'h4001_0000);
    doAcc(1'b1, 32'hc300_0000, 32'h55, 4'h1);
    chk("R8 partial uart", {26'h0, gotSel}, 32'h0);
    doAcc(1'b1, 32'hc300_0000, 32'h55, 4'hf);
    chk("R8 full uart", {26'h0, gotSel}, 32'h8);
    doAcc(1'b1, 32'hd000_0001, 32'h5500, 4'h2);
    chk("R8 byte loader ram", {26'h0, gotSel}, 32'h20);
    doAcc(1'b1, sysA(5), 32'h0000_0041, 4'h1);
    chk("R8 debug strobe", {31'h0, gotDbg}, 32'h1);
    chk("R8 debug byte", {24'h0, gotDbgB}, 32'h41);
    doAcc(1'b1, sysA(4), 32'h1, 4'h1);
    chk("R8 partial switch", {31'h0, appMode}, 32'h0);

    // R4 switch
    doAcc(1'b1, sysA(4), 32'h0, 4'hf);
    chk("R4 zero switch", {31'h0, appMode}, 32'h0);
    doAcc(1'b1, sysA(4), 32'h8000_0000, 4'hf);
    chk("R4 switch", {31'h0, appMode}, 32'h1);

    sweep(1'b1);
    checkIds();

    // R6 write protection, R10 blocked write still completes
    doAcc(1'b1, sysA(8), 32'hdead_beef, 4'hf);
    chk("R10 blocked ready", {31'h0, gotRdy}, 32'h1);
    doAcc(1'b1, sysA(9), 32'hdead_beef, 4'hf);
    doAcc(1'b1, sysA(19), 32'hdead_beef, 4'hf);
    doAcc(1'b0, sysA(8), 0, 0); chk("R6 addr ro", gotRd, 32'h4001_0000);
    doAcc(1'b0, sysA(9), 0, 0); chk("R6 size ro", gotRd, 32'h0000_1f00);
    doAcc(1'b0, sysA(19), 0, 0); chk("R6 cdi ro", gotRd, 32'h0404_0404);
    doAcc(1'b1, sysA(4), 32'h0, 4'hf);
    chk("R4 sticky", {31'h0, appMode}, 32'h1);

    // R9 software reset
    @(negedge clk); softRst = 1'b1;
    @(posedge clk); #1 softRst = 1'b0;
    chk("R9 mode cleared", {31'h0, appMode}, 32'h0);
    doAcc(1'b0, sysA(8), 0, 0); chk("R9 addr cleared", gotRd, 32'h0);
    doAcc(1'b0, sysA(9), 0, 0); chk("R9 size cleared", gotRd, 32'h0);
    doAcc(1'b0, sysA(23), 0, 0); chk("R9 cdi cleared", gotRd, 32'h0);
    doAcc(1'b0, 32'hc200_0000, 0, 0);
    chk("R9 secret visible", {26'h0, gotSel}, 32'h4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule